// File: doc/BRIEF.md
# TL-UL to AXI4 Request Bridge

This block sits between a TileLink Uncached Lightweight (TL-UL) host and an AXI4 subordinate. The host presents each request on the A channel, where reads and writes share one set of signals. The bridge takes the request and issues it on the AXI side: a read goes out on AR, and a write goes out on both AW and W. The AXI reply comes back on R or B. The bridge turns that reply into a single TL-UL D-channel response, which carries the data, the error flag and the original source and size.

Only one transaction is in flight at a time. When the A-channel handshake completes, the bridge stores the request fields in registers, so the host may change its A inputs straight away. A small state machine follows the AW and W handshakes separately. These two may complete in the same cycle or in either order, and each valid drops once its own handshake is done. The bridge asks for the write response only after both handshakes have finished. A request with an opcode the bridge does not recognise is answered at once with an error, and nothing appears on the AXI side.

Top module: `tl2axi_bridge`

## Requirements
- R1: While reset is held, the A-channel ready output is 1 and every other valid and ready output of the bridge (D valid, AW/W/AR valid, B/R ready) is 0.
- R2: A request with opcode 4 (Get) produces exactly one AR beat. That beat carries the captured address, ARLEN 0, ARSIZE equal to the TL-UL size zero-extended to 3 bits, and ARBURST 2'b01 (INCR). AW and W stay idle, and RREADY rises only after the AR handshake.
- R3: A request with opcode 0 (PutFullData) or 1 (PutPartialData) produces one AW beat and one W beat. AW carries the address, AWLEN 0, the size zero-extended to 3 bits, and AWBURST 2'b01. W carries the data, WSTRB equal to the TL-UL mask, and WLAST 1. AR stays idle.
- R4: The AW and W handshakes may complete in the same cycle or in either order. Each valid drops in the cycle after its own handshake and is not raised again for that request. BREADY is 1 only after both handshakes have completed.
- R5: Once a request has been accepted, A-channel ready stays 0 until the D-channel handshake of its response. It returns to 1 in the cycle after that handshake.
- R6: A read response has D opcode 1 (AccessAckData) and D data equal to RDATA. D source and D size echo the stored request.
- R7: A write response has D opcode 0 (AccessAck) and D data 0. D source and D size echo the stored request.
- R8: D error is 1 when the BRESP or RRESP value that ended the transaction is 2 (SLVERR) or 3 (DECERR). It is 0 when that value is 0 (OKAY) or 1 (EXOKAY). The flag belongs to the same D beat as the response.
- R9: An A request with any opcode other than 0, 1 or 4 causes no AXI valid. It is answered on the next cycle with D opcode 0, D data 0 and D error 1.
- R10: Each valid output holds, with its payload unchanged, until its ready is seen. This covers AW, W, AR and D.
- R11: Request fields are captured at the A-channel handshake. Changing the A inputs afterwards does not change the AXI address, data, strobe or size outputs, or the echoed D fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tl_a_valid_i | input | 1 | A-channel request valid |
| tl_a_ready_o | output | 1 | A-channel request ready |
| tl_a_opcode_i | input | 3 | Request opcode (0 put full, 1 put partial, 4 get) |
| tl_a_size_i | input | SZW | Log2 of the access size in bytes |
| tl_a_source_i | input | SRCW | Requester tag |
| tl_a_address_i | input | AW | Byte address |
| tl_a_mask_i | input | DW/8 | Byte lane mask |
| tl_a_data_i | input | DW | Write data |
| tl_d_valid_o | output | 1 | D-channel response valid |
| tl_d_ready_i | input | 1 | D-channel response ready |
| tl_d_opcode_o | output | 3 | Response opcode (0 ack, 1 ack with data) |
| tl_d_size_o | output | SZW | Echoed size |
| tl_d_source_o | output | SRCW | Echoed requester tag |
| tl_d_data_o | output | DW | Read data |
| tl_d_error_o | output | 1 | Response error flag |
| axi_awvalid_o | output | 1 | Write address valid |
| axi_awready_i | input | 1 | Write address ready |
| axi_awaddr_o | output | AW | Write address |
| axi_awlen_o | output | 8 | Burst length minus one (always 0) |
| axi_awsize_o | output | 3 | Beat size |
| axi_awburst_o | output | 2 | Burst type (INCR) |
| axi_wvalid_o | output | 1 | Write data valid |
| axi_wready_i | input | 1 | Write data ready |
| axi_wdata_o | output | DW | Write data |
| axi_wstrb_o | output | DW/8 | Write strobes |
| axi_wlast_o | output | 1 | Last write beat (always 1) |
| axi_bvalid_i | input | 1 | Write response valid |
| axi_bready_o | output | 1 | Write response ready |
| axi_bresp_i | input | 2 | Write response code |
| axi_arvalid_o | output | 1 | Read address valid |
| axi_arready_i | input | 1 | Read address ready |
| axi_araddr_o | output | AW | Read address |
| axi_arlen_o | output | 8 | Burst length minus one (always 0) |
| axi_arsize_o | output | 3 | Beat size |
| axi_arburst_o | output | 2 | Burst type (INCR) |
| axi_rvalid_i | input | 1 | Read data valid |
| axi_rready_o | output | 1 | Read data ready |
| axi_rdata_i | input | DW | Read data |
| axi_rresp_i | input | 2 | Read response code |

## Verification
Writes are swept over both put opcodes. Each one runs with AW-ready and W-ready delays of 0 to 2 cycles, which covers the simultaneous case, W finishing first and AW finishing first. This is what separates a correct handshake tracker from one that drops a late beat or reissues an early one. Every write and read is also run with all four response codes, which shows that exactly SLVERR and DECERR set the error flag in the same D beat. D-ready stalls of up to two cycles expose any response payload that moves while it is held. After each accepted request the A inputs are driven to their bitwise inverse, so a bridge that forwards live inputs instead of captured ones is caught. The five unused opcodes are each sent once to confirm the error-only path with no AXI activity.

// File: rtl/tl2axi_pkg.sv
package tl2axi_pkg;

  localparam logic [2:0] TL_OP_PUT_FULL = 3'd0;
  localparam logic [2:0] TL_OP_PUT_PART = 3'd1;
  localparam logic [2:0] TL_OP_GET      = 3'd4;
  localparam logic [2:0] TL_OP_ACK      = 3'd0;
  localparam logic [2:0] TL_OP_ACK_DATA = 3'd1;

  localparam logic [1:0] AXI_BURST_INCR = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_BOTH,
    ST_WR_NEED_AW,
    ST_WR_NEED_W,
    ST_WR_RESP,
    ST_RD_ADDR,
    ST_RD_RESP,
    ST_RESP
  } bridge_state_e;

  typedef enum logic [1:0] {
    KIND_READ,
    KIND_WRITE,
    KIND_BAD
  } req_kind_e;

  // Sort an A-channel opcode into the AXI path it takes.
  function automatic req_kind_e classify_op(input logic [2:0] op);
    if (op == TL_OP_GET) return KIND_READ;
    if (op == TL_OP_PUT_FULL || op == TL_OP_PUT_PART) return KIND_WRITE;
    return KIND_BAD;
  endfunction

  // SLVERR (2) and DECERR (3) both have the upper bit set.
  function automatic logic resp_fails(input logic [1:0] resp);
    return resp[1];
  endfunction

endpackage

// File: rtl/tl2axi_req_reg.sv
module tl2axi_req_reg #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SRCW = 8,
  parameter int SZW  = 2,
  localparam int STRB_W = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [STRB_W-1:0] mask_i,
  input  logic [SZW-1:0]    size_i,
  input  logic [SRCW-1:0]   source_i,
  output logic [AW-1:0]     addr_q,
  output logic [DW-1:0]     data_q,
  output logic [STRB_W-1:0] mask_q,
  output logic [SZW-1:0]    size_q,
  output logic [SRCW-1:0]   source_q
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      data_q   <= '0;
      mask_q   <= '0;
      size_q   <= '0;
      source_q <= '0;
    end else if (capture_i) begin
      addr_q   <= addr_i;
      data_q   <= data_i;
      mask_q   <= mask_i;
      size_q   <= size_i;
      source_q <= source_i;
    end
  end

endmodule

// File: rtl/tl2axi_fsm.sv
module tl2axi_fsm
  import tl2axi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_hs_i,
  input  req_kind_e     a_kind_i,
  input  logic          aw_hs_i,
  input  logic          w_hs_i,
  input  logic          b_hs_i,
  input  logic          ar_hs_i,
  input  logic          r_hs_i,
  input  logic          d_hs_i,
  output bridge_state_e state_o,
  output logic          a_ready_o,
  output logic          aw_valid_o,
  output logic          w_valid_o,
  output logic          b_ready_o,
  output logic          ar_valid_o,
  output logic          r_ready_o,
  output logic          d_valid_o
);

  bridge_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (a_hs_i) begin
        unique case (a_kind_i)
          KIND_READ:  state_d = ST_RD_ADDR;
          KIND_WRITE: state_d = ST_WR_BOTH;
          default:    state_d = ST_RESP;
        endcase
      end
      ST_WR_BOTH: begin
        if (aw_hs_i && w_hs_i) state_d = ST_WR_RESP;
        else if (aw_hs_i)      state_d = ST_WR_NEED_W;
        else if (w_hs_i)       state_d = ST_WR_NEED_AW;
      end
      ST_WR_NEED_AW: if (aw_hs_i) state_d = ST_WR_RESP;
      ST_WR_NEED_W:  if (w_hs_i)  state_d = ST_WR_RESP;
      ST_WR_RESP:    if (b_hs_i)  state_d = ST_RESP;
      ST_RD_ADDR:    if (ar_hs_i) state_d = ST_RD_RESP;
      ST_RD_RESP:    if (r_hs_i)  state_d = ST_RESP;
      ST_RESP:       if (d_hs_i)  state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign a_ready_o  = (state_q == ST_IDLE);
  assign aw_valid_o = (state_q == ST_WR_BOTH) || (state_q == ST_WR_NEED_AW);
  assign w_valid_o  = (state_q == ST_WR_BOTH) || (state_q == ST_WR_NEED_W);
  assign b_ready_o  = (state_q == ST_WR_RESP);
  assign ar_valid_o = (state_q == ST_RD_ADDR);
  assign r_ready_o  = (state_q == ST_RD_RESP);
  assign d_valid_o  = (state_q == ST_RESP);

endmodule

// File: rtl/tl2axi_rsp.sv
module tl2axi_rsp
  import tl2axi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          b_hs_i,
  input  logic [1:0]    bresp_i,
  input  logic          r_hs_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [1:0]    rresp_i,
  input  logic          bad_hs_i,
  output logic [2:0]    opcode_q,
  output logic [DW-1:0] data_q,
  output logic          error_q
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q <= TL_OP_ACK;
      data_q   <= '0;
      error_q  <= 1'b0;
    end else if (r_hs_i) begin
      opcode_q <= TL_OP_ACK_DATA;
      data_q   <= rdata_i;
      error_q  <= resp_fails(rresp_i);
    end else if (b_hs_i) begin
      opcode_q <= TL_OP_ACK;
      data_q   <= '0;
      error_q  <= resp_fails(bresp_i);
    end else if (bad_hs_i) begin
      opcode_q <= TL_OP_ACK;
      data_q   <= '0;
      error_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/tl2axi_bridge.sv
module tl2axi_bridge
  import tl2axi_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SRCW = 8,
  parameter int SZW  = 2,
  localparam int STRB_W = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tl_a_valid_i,
  output logic              tl_a_ready_o,
  input  logic [2:0]        tl_a_opcode_i,
  input  logic [SZW-1:0]    tl_a_size_i,
  input  logic [SRCW-1:0]   tl_a_source_i,
  input  logic [AW-1:0]     tl_a_address_i,
  input  logic [STRB_W-1:0] tl_a_mask_i,
  input  logic [DW-1:0]     tl_a_data_i,
  output logic              tl_d_valid_o,
  input  logic              tl_d_ready_i,
  output logic [2:0]        tl_d_opcode_o,
  output logic [SZW-1:0]    tl_d_size_o,
  output logic [SRCW-1:0]   tl_d_source_o,
  output logic [DW-1:0]     tl_d_data_o,
  output logic              tl_d_error_o,
  output logic              axi_awvalid_o,
  input  logic              axi_awready_i,
  output logic [AW-1:0]     axi_awaddr_o,
  output logic [7:0]        axi_awlen_o,
  output logic [2:0]        axi_awsize_o,
  output logic [1:0]        axi_awburst_o,
  output logic              axi_wvalid_o,
  input  logic              axi_wready_i,
  output logic [DW-1:0]     axi_wdata_o,
  output logic [STRB_W-1:0] axi_wstrb_o,
  output logic              axi_wlast_o,
  input  logic              axi_bvalid_i,
  output logic              axi_bready_o,
  input  logic [1:0]        axi_bresp_i,
  output logic              axi_arvalid_o,
  input  logic              axi_arready_i,
  output logic [AW-1:0]     axi_araddr_o,
  output logic [7:0]        axi_arlen_o,
  output logic [2:0]        axi_arsize_o,
  output logic [1:0]        axi_arburst_o,
  input  logic              axi_rvalid_i,
  output logic              axi_rready_o,
  input  logic [DW-1:0]     axi_rdata_i,
  input  logic [1:0]        axi_rresp_i
);

  // Handshake events, named for the checker.
  logic a_hs, aw_hs, w_hs, b_hs, ar_hs, r_hs, d_hs, bad_hs;
  req_kind_e     a_kind;
  bridge_state_e state;

  logic [AW-1:0]     q_addr;
  logic [DW-1:0]     q_data;
  logic [STRB_W-1:0] q_mask;
  logic [SZW-1:0]    q_size;
  logic [SRCW-1:0]   q_source;

  assign a_kind = classify_op(tl_a_opcode_i);
  assign a_hs   = tl_a_valid_i  && tl_a_ready_o;
  assign aw_hs  = axi_awvalid_o && axi_awready_i;
  assign w_hs   = axi_wvalid_o  && axi_wready_i;
  assign b_hs   = axi_bvalid_i  && axi_bready_o;
  assign ar_hs  = axi_arvalid_o && axi_arready_i;
  assign r_hs   = axi_rvalid_i  && axi_rready_o;
  assign d_hs   = tl_d_valid_o  && tl_d_ready_i;
  assign bad_hs = a_hs && (a_kind == KIND_BAD);

  tl2axi_req_reg #(.AW(AW), .DW(DW), .SRCW(SRCW), .SZW(SZW)) i_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(a_hs),
    .addr_i   (tl_a_address_i),
    .data_i   (tl_a_data_i),
    .mask_i   (tl_a_mask_i),
    .size_i   (tl_a_size_i),
    .source_i (tl_a_source_i),
    .addr_q   (q_addr),
    .data_q   (q_data),
    .mask_q   (q_mask),
    .size_q   (q_size),
    .source_q (q_source)
  );

  tl2axi_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_hs_i    (a_hs),
    .a_kind_i  (a_kind),
    .aw_hs_i   (aw_hs),
    .w_hs_i    (w_hs),
    .b_hs_i    (b_hs),
    .ar_hs_i   (ar_hs),
    .r_hs_i    (r_hs),
    .d_hs_i    (d_hs),
    .state_o   (state),
    .a_ready_o (tl_a_ready_o),
    .aw_valid_o(axi_awvalid_o),
    .w_valid_o (axi_wvalid_o),
    .b_ready_o (axi_bready_o),
    .ar_valid_o(axi_arvalid_o),
    .r_ready_o (axi_rready_o),
    .d_valid_o (tl_d_valid_o)
  );

  tl2axi_rsp #(.DW(DW)) i_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .b_hs_i  (b_hs),
    .bresp_i (axi_bresp_i),
    .r_hs_i  (r_hs),
    .rdata_i (axi_rdata_i),
    .rresp_i (axi_rresp_i),
    .bad_hs_i(bad_hs),
    .opcode_q(tl_d_opcode_o),
    .data_q  (tl_d_data_o),
    .error_q (tl_d_error_o)
  );

  assign axi_awaddr_o  = q_addr;
  assign axi_awlen_o   = 8'd0;
  assign axi_awsize_o  = 3'(q_size);
  assign axi_awburst_o = AXI_BURST_INCR;
  assign axi_wdata_o   = q_data;
  assign axi_wstrb_o   = q_mask;
  assign axi_wlast_o   = 1'b1;
  assign axi_araddr_o  = q_addr;
  assign axi_arlen_o   = 8'd0;
  assign axi_arsize_o  = 3'(q_size);
  assign axi_arburst_o = AXI_BURST_INCR;
  assign tl_d_size_o   = q_size;
  assign tl_d_source_o = q_source;

endmodule

// File: rtl/tl2axi_checker.sv
module tl2axi_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int STRB_W = DW / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_hs,
  input logic              aw_hs,
  input logic              w_hs,
  input logic              b_hs,
  input logic              r_hs,
  input logic              a_ready,
  input logic              d_valid,
  input logic              d_ready,
  input logic [2:0]        d_opcode,
  input logic [DW-1:0]     d_data,
  input logic              d_error,
  input logic              awvalid,
  input logic              awready,
  input logic [AW-1:0]     awaddr,
  input logic              wvalid,
  input logic              wready,
  input logic [DW-1:0]     wdata,
  input logic [STRB_W-1:0] wstrb,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              arvalid,
  input logic              arready,
  input logic [AW-1:0]     araddr,
  input logic [DW-1:0]     rdata,
  input logic [1:0]        rresp
);

  assert_single_outstanding_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_ready && d_valid));

  assert_accept_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_hs |=> !a_ready);

  assert_path_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arvalid && (awvalid || wvalid)));

  assert_aw_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

  assert_w_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb)));

  assert_ar_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));

  assert_d_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid && !d_ready) |=> (d_valid && $stable(d_data) && $stable(d_error) && $stable(d_opcode)));

  assert_aw_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_hs |=> !awvalid);

  assert_w_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_hs |=> !wvalid);

  assert_bready_late_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bready |-> (!awvalid && !wvalid));

  assert_b_error_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_hs |=> (d_valid && d_error == ($past(bresp) >= 2'd2)));

  assert_r_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_hs |=> (d_valid && d_opcode == 3'd1 && d_data == $past(rdata) &&
              d_error == ($past(rresp) >= 2'd2)));

endmodule

bind tl2axi_bridge tl2axi_checker #(.AW(AW), .DW(DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_hs    (a_hs),
  .aw_hs   (aw_hs),
  .w_hs    (w_hs),
  .b_hs    (b_hs),
  .r_hs    (r_hs),
  .a_ready (tl_a_ready_o),
  .d_valid (tl_d_valid_o),
  .d_ready (tl_d_ready_i),
  .d_opcode(tl_d_opcode_o),
  .d_data  (tl_d_data_o),
  .d_error (tl_d_error_o),
  .awvalid (axi_awvalid_o),
  .awready (axi_awready_i),
  .awaddr  (axi_awaddr_o),
  .wvalid  (axi_wvalid_o),
  .wready  (axi_wready_i),
  .wdata   (axi_wdata_o),
  .wstrb   (axi_wstrb_o),
  .bready  (axi_bready_o),
  .bresp   (axi_bresp_i),
  .arvalid (axi_arvalid_o),
  .arready (axi_arready_i),
  .araddr  (axi_araddr_o),
  .rdata   (axi_rdata_i),
  .rresp   (axi_rresp_i)
);

// File: tb/test_tl2axi_bridge.sv
`timescale 1ns/1ps
module test_tl2axi_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_valid = 0, a_ready;
  logic [2:0]  a_opcode = 0;
  logic [1:0]  a_size = 0;
  logic [7:0]  a_source = 0;
  logic [31:0] a_address = 0;
  logic [3:0]  a_mask = 0;
  logic [31:0] a_data = 0;
  logic        d_valid, d_ready = 0;
  logic [2:0]  d_opcode;
  logic [1:0]  d_size;
  logic [7:0]  d_source;
  logic [31:0] d_data;
  logic        d_error;
  logic        awvalid, awready = 0;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        wvalid, wready = 0;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        wlast;
  logic        bvalid = 0, bready;
  logic [1:0]  bresp = 0;
  logic        arvalid, arready = 0;
  logic [31:0] araddr;
  logic [7:0]  arlen;
  logic [2:0]  arsize;
  logic [1:0]  arburst;
  logic        rvalid = 0, rready;
  logic [31:0] rdata = 0;
  logic [1:0]  rresp = 0;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  tl2axi_bridge i_tl2axi_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .tl_a_valid_i(a_valid), .tl_a_ready_o(a_ready), .tl_a_opcode_i(a_opcode),
    .tl_a_size_i(a_size), .tl_a_source_i(a_source), .tl_a_address_i(a_address),
    .tl_a_mask_i(a_mask), .tl_a_data_i(a_data),
    .tl_d_valid_o(d_valid), .tl_d_ready_i(d_ready), .tl_d_opcode_o(d_opcode),
    .tl_d_size_o(d_size), .tl_d_source_o(d_source), .tl_d_data_o(d_data),
    .tl_d_error_o(d_error),
    .axi_awvalid_o(awvalid), .axi_awready_i(awready), .axi_awaddr_o(awaddr),
    .axi_awlen_o(awlen), .axi_awsize_o(awsize), .axi_awburst_o(awburst),
    .axi_wvalid_o(wvalid), .axi_wready_i(wready), .axi_wdata_o(wdata),
    .axi_wstrb_o(wstrb), .axi_wlast_o(wlast),
    .axi_bvalid_i(bvalid), .axi_bready_o(bready), .axi_bresp_i(bresp),
    .axi_arvalid_o(arvalid), .axi_arready_i(arready), .axi_araddr_o(araddr),
    .axi_arlen_o(arlen), .axi_arsize_o(arsize), .axi_arburst_o(arburst),
    .axi_rvalid_i(rvalid), .axi_rready_o(rready), .axi_rdata_i(rdata),
    .axi_rresp_i(rresp)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // Present a request; returns at the negedge after acceptance with the
  // A inputs inverted, so later outputs must come from captured copies (R11).
  task automatic send_a(input logic [2:0] op, input logic [31:0] addr, data,
                        input logic [3:0] mask, input logic [1:0] size, input logic [7:0] src);
    chk("R5 ready idle", 64'(a_ready), 64'd1);
    a_valid = 1; a_opcode = op; a_address = addr; a_data = data;
    a_mask = mask; a_size = size; a_source = src;
    @(negedge clk);
    a_valid = 0; a_opcode = ~op; a_address = ~addr; a_data = ~data;
    a_mask = ~mask; a_size = ~size; a_source = ~src;
  endtask

  // Hold D ready low for stall cycles while checking the response stays put.
  task automatic take_d(input string req, input logic [2:0] op, input logic [31:0] data,
                        input logic err, input logic [1:0] size, input logic [7:0] src,
                        input int stall);
    for (int k = 0; k <= stall; k++) begin
      chk(req, {d_valid, d_opcode, d_size, d_source, d_data, a_ready},
               {1'b1, op, size, src, data, 1'b0});
      chk("R8 error flag", 64'(d_error), 64'(err));
      d_ready = (k == stall);
      @(negedge clk);
    end
    d_ready = 0;
    chk("R5 reopen", {d_valid, a_ready}, 2'b01);
  endtask

  task automatic do_write(input logic [2:0] op, input logic [31:0] addr, data,
                          input logic [3:0] mask, input logic [1:0] size, input logic [7:0] src,
                          input int aw_dly, input int w_dly, input logic [1:0] resp, input int stall);
    bit aw_done = 0, w_done = 0;
    int c = 0;
    send_a(op, addr, data, mask, size, src);
    while (!(aw_done && w_done)) begin
      chk("R4 valids", {awvalid, wvalid, bready}, {!aw_done, !w_done, 1'b0});
      chk("R3 no read", {arvalid, a_ready}, 2'b00);
      if (!aw_done)
        chk("R3 aw fields", {awaddr, awlen, awsize, awburst},
                            {addr, 8'd0, 1'b0, size, 2'b01});
      if (!w_done)
        chk("R3 w fields", {wdata, wstrb, wlast}, {data, mask, 1'b1});
      awready = !aw_done && (c >= aw_dly);
      wready  = !w_done  && (c >= w_dly);
      @(negedge clk);
      if (awready) aw_done = 1;
      if (wready)  w_done  = 1;
      awready = 0; wready = 0; c++;
    end
    chk("R4 bready after both", {awvalid, wvalid, bready, arvalid}, 4'b0010);
    bvalid = 1; bresp = resp;
    @(negedge clk);
    bvalid = 0; bresp = ~resp;
    take_d("R7 write resp", 3'd0, 32'd0, resp >= 2, size, src, stall);
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [1:0] size, input logic [7:0] src,
                         input int ar_dly, input logic [31:0] rd, input logic [1:0] resp,
                         input int stall);
    send_a(3'd4, addr, 32'hdead_beef, 4'hf, size, src);
    for (int c = 0; c <= ar_dly; c++) begin
      chk("R2 ar only", {arvalid, awvalid, wvalid, rready, a_ready}, 5'b10000);
      chk("R2 ar fields", {araddr, arlen, arsize, arburst}, {addr, 8'd0, 1'b0, size, 2'b01});
      arready = (c == ar_dly);
      @(negedge clk);
      arready = 0;
    end
    chk("R2 rready after ar", {arvalid, rready}, 2'b01);
    rvalid = 1; rdata = rd; rresp = resp;
    @(negedge clk);
    rvalid = 0; rdata = ~rd; rresp = ~resp;
    take_d("R6 read resp", 3'd1, rd, resp >= 2, size, src, stall);
  endtask

  task automatic do_bad(input logic [2:0] op, input logic [1:0] size, input logic [7:0] src);
    send_a(op, 32'h0000_0040, 32'h1234_5678, 4'h3, size, src);
    chk("R9 no axi", {awvalid, wvalid, arvalid}, 3'b000);
    take_d("R9 bad opcode", 3'd0, 32'd0, 1'b1, size, src, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: all requirements, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int idx = 0;
    @(negedge clk);
    chk("R1 reset outputs", {a_ready, d_valid, awvalid, wvalid, arvalid, bready, rready},
                            7'b1000000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int op = 0; op < 2; op++)
      for (int ad = 0; ad < 3; ad++)
        for (int wd = 0; wd < 3; wd++)
          for (int rs = 0; rs < 4; rs++) begin
            do_write(3'(op), 32'h1000_0000 + 32'(idx) * 32'd4,
                     32'(idx) * 32'h0101_0101 ^ 32'h5a5a_0000, 4'(idx + 1),
                     2'(idx % 3), 8'(idx * 7), ad, wd, 2'(rs), idx % 3);
            idx++;
          end

    for (int ad = 0; ad < 3; ad++)
      for (int rs = 0; rs < 4; rs++) begin
        do_read(32'h2000_0000 + 32'(idx) * 32'd8, 2'(idx % 3), 8'(idx * 5), ad,
                32'(idx) * 32'h0013_0017 + 32'hc0de_0000, 2'(rs), (idx + 1) % 3);
        idx++;
      end

    for (int op = 0; op < 8; op++)
      if (op != 0 && op != 1 && op != 4)
        do_bad(3'(op), 2'(op % 3), 8'(op + 100));

    summary();
    $finish;
  end

endmodule